// File: doc/BRIEF.md
# Timer with PWM and capture

A 16-bit up-counting timer driven by an external count-source event input. A power-of-two prescaler thins those events before they reach the counter. When the counter reaches a programmable period it returns to zero and raises an overflow pending flag.

The same counter serves three uses, chosen by a mode field:

- **Plain timer:** the counter simply runs and overflows.
- **Pulse-width output:** the counter is compared against a duty register to drive a square wave.
- **Input capture:** the rising edge of an asynchronous capture input copies the counter into the duty register. This register is shared between the two uses, and a capture raises its own pending flag.

Software programs the block through a small address/data register port with one-cycle read latency. A single interrupt output combines the two pending flags, each with its own mask.

Top module: `pwm_cap_timer`

## Requirements
- R1: After reset the counter reads 0, the control word reads 0, both pending flags read 0, and `pwm_out` and `irq` are low. The period register resets to 0xFFFF, so a counter started from 0xFFFE reaches 0xFFFF on one tick and wraps to 0 on the next.
- R2: The control register is at address 0, with these fields:
  - bit 0: run enable
  - bits 2:1: mode (0 = timer, 1 = pulse output, 2 = capture, 3 = timer)
  - bits 5:3: prescale code N
  - bit 6: overflow interrupt enable
  - bit 7: capture interrupt enable

  With prescale code N, the counter advances once per 2^N count-source events (1 to 128).
- R3: On a counter advance, if the count equals the period (address 3), the count becomes 0 and the overflow pending flag (status bit 0, address 1) is set to 1. Otherwise the count increases by one.
- R4: While the enable is 0, the counter does not move. The prescaler's partial event count is discarded whenever the block is disabled, and whenever a control write changes the prescale code.
- R5: The counter (address 2) is readable and writable. A software write to it takes priority over an advance in the same cycle.
- R6: The period register is write-only, and reads at address 3 return 0. Read data appears one cycle after the address is presented.
- R7: In pulse-output mode with the enable set, `pwm_out` is high exactly when count < duty (duty at address 4), one cycle after the count. A duty of 0 gives a constant low, and a duty above the period gives a constant high. In other modes, or when disabled, `pwm_out` is low.
- R8: In capture mode with the enable set, a rising edge on `cap_in` is passed through two synchronising flops. It then copies the counter into the duty register and sets the capture pending flag (status bit 1) on the third clock edge after the input rises.
- R9: Outside capture mode, edges on `cap_in` leave the duty register and the capture pending flag unchanged.
- R10: When a capture and a software write to the duty register fall on the same cycle, the captured count is kept.
- R11: Writing the status register clears each pending flag whose written bit is 0, and leaves it unchanged where the written bit is 1. A hardware set in the same cycle wins over the clear.
- R12: `irq` is high, one cycle later, when (overflow pending and overflow interrupt enable) or (capture pending and capture interrupt enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data for `addr` |
| cnt_evt | input | 1 | Count-source event, one pulse per event |
| cap_in | input | 1 | Asynchronous capture input, rising edge active |
| pwm_out | output | 1 | Registered pulse-width output |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach is a capture landing in the same cycle as a software write to the duty register. The bench counts the synchroniser's flops from the moment it raises `cap_in`, and issues the duty write on exactly the third edge. It then reads back the duty register to see which value won.

A second corner is the prescaler discard on disable. The bench feeds a partial group of events, toggles the enable, and confirms that the next advance needs a full new group of 2^N events.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_TIMER   = 2'd0,
    MODE_PWM     = 2'd1,
    MODE_CAPTURE = 2'd2,
    MODE_SPARE   = 2'd3
  } tmr_mode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd3;
  localparam logic [ADDR_W-1:0] A_DUTY   = 3'd4;

  localparam int CTRL_W    = 8;
  localparam int B_EN      = 0;
  localparam int B_MODE_LO = 1;
  localparam int B_PSC_LO  = 3;
  localparam int B_OVF_IE  = 6;
  localparam int B_CAP_IE  = 7;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              evt,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int DIV_W = (1 << CODE_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = ~({DIV_W{1'b1}} << code);
  assign tick = evt && !clr && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr) div_q <= '0;
    else if (evt)   div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_capsync.sv
module tmr_capsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  assign rise = sh_q[STAGES-1] && !sh_q[STAGES];
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] duty,
  output logic          pwm
);
  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= active && (count < duty);
  end
endmodule

// File: rtl/pwm_cap_timer.sv
module pwm_cap_timer
  import tmr_pkg::*;
#(
  parameter int CW     = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     rdata,
  input  logic              cnt_evt,
  input  logic              cap_in,
  output logic              pwm_out,
  output logic              irq
);
  localparam int MODE_HI = B_MODE_LO + 1;
  localparam int PSC_HI  = B_PSC_LO + CODE_W - 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CW-1:0]     count_q, period_q, duty_q, rdata_q;
  logic              ovf_pend_q, cap_pend_q, irq_q;

  logic ctrl_wr, stat_wr, cnt_wr, per_wr, duty_wr;
  assign ctrl_wr = wr_en && (addr == A_CTRL);
  assign stat_wr = wr_en && (addr == A_STATUS);
  assign cnt_wr  = wr_en && (addr == A_COUNT);
  assign per_wr  = wr_en && (addr == A_PERIOD);
  assign duty_wr = wr_en && (addr == A_DUTY);

  logic              en, ovf_ie, cap_ie;
  tmr_mode_e         mode;
  logic [CODE_W-1:0] psc_code;
  assign en       = ctrl_q[B_EN];
  assign mode     = tmr_mode_e'(ctrl_q[MODE_HI:B_MODE_LO]);
  assign psc_code = ctrl_q[PSC_HI:B_PSC_LO];
  assign ovf_ie   = ctrl_q[B_OVF_IE];
  assign cap_ie   = ctrl_q[B_CAP_IE];

  logic pwm_active, cap_active;
  assign pwm_active = en && (mode == MODE_PWM);
  assign cap_active = en && (mode == MODE_CAPTURE);

  logic psc_clr, tick, cap_rise, wrap, cap_take;
  assign psc_clr  = !en || (ctrl_wr && (wdata[PSC_HI:B_PSC_LO] != psc_code));
  assign wrap     = en && tick && (count_q == period_q) && !cnt_wr;
  assign cap_take = cap_active && cap_rise;

  tmr_prescale #(.CODE_W(CODE_W)) u_psc (
    .clk (clk),
    .rst (rst),
    .clr (psc_clr),
    .evt (cnt_evt),
    .code(psc_code),
    .tick(tick)
  );

  tmr_capsync #(.STAGES(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_in(cap_in),
    .rise    (cap_rise)
  );

  tmr_pwm #(.CW(CW)) u_pwm (
    .clk   (clk),
    .rst   (rst),
    .active(pwm_active),
    .count (count_q),
    .duty  (duty_q),
    .pwm   (pwm_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '1;
    end else begin
      if (ctrl_wr) ctrl_q   <= wdata[CTRL_W-1:0];
      if (per_wr)  period_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 count_q <= '0;
    else if (cnt_wr)         count_q <= wdata;
    else if (wrap)           count_q <= '0;
    else if (en && tick)     count_q <= count_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           duty_q <= '0;
    else if (cap_take) duty_q <= count_q;
    else if (duty_wr)  duty_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_pend_q <= 1'b0;
      cap_pend_q <= 1'b0;
    end else begin
      ovf_pend_q <= wrap     || (ovf_pend_q && !(stat_wr && !wdata[0]));
      cap_pend_q <= cap_take || (cap_pend_q && !(stat_wr && !wdata[1]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= (ovf_pend_q && ovf_ie) || (cap_pend_q && cap_ie);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      unique case (addr)
        A_CTRL:   rdata_q <= CW'(ctrl_q);
        A_STATUS: rdata_q <= CW'({cap_pend_q, ovf_pend_q});
        A_COUNT:  rdata_q <= count_q;
        A_DUTY:   rdata_q <= duty_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          tick,
  input logic          cnt_wr,
  input logic [CW-1:0] count,
  input logic [CW-1:0] period,
  input logic [CW-1:0] duty,
  input logic          ovf_pend,
  input logic          cap_pend,
  input logic          cap_take,
  input logic          pwm_active,
  input logic          ovf_ie,
  input logic          cap_ie,
  input logic [2:0]    addr,
  input logic [CW-1:0] rdata,
  input logic          pwm_out,
  input logic          irq
);
  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (en && tick && !cnt_wr && count == period) |=> (count == '0 && ovf_pend));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!en && !cnt_wr) |=> $stable(count));

  assert_period_read_R6: assert property (@(posedge clk) disable iff (rst)
    (addr == 3'd3) |=> (rdata == '0));

  assert_pwm_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !pwm_active |=> !pwm_out);

  assert_pwm_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (duty == '0) |=> !pwm_out);

  assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
    cap_take |=> (duty == $past(count) && cap_pend));

  assert_irq_R12: assert property (@(posedge clk) disable iff (rst)
    ((ovf_pend && ovf_ie) || (cap_pend && cap_ie)) |=> irq);

  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (!(ovf_pend && ovf_ie) && !(cap_pend && cap_ie)) |=> !irq);
endmodule

bind pwm_cap_timer tmr_checker #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .tick      (tick),
  .cnt_wr    (cnt_wr),
  .count     (count_q),
  .period    (period_q),
  .duty      (duty_q),
  .ovf_pend  (ovf_pend_q),
  .cap_pend  (cap_pend_q),
  .cap_take  (cap_take),
  .pwm_active(pwm_active),
  .ovf_ie    (ovf_ie),
  .cap_ie    (cap_ie),
  .addr      (addr),
  .rdata     (rdata),
  .pwm_out   (pwm_out),
  .irq       (irq)
);

// File: tb/pwm_cap_timer_test.sv
`timescale 1ns/1ps
module pwm_cap_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        cnt_evt = 1'b0;
  logic        cap_in = 1'b0;
  logic        pwm_out, irq;

  int errors = 0;
  int checks = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  pwm_cap_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cnt_evt(cnt_evt), .cap_in(cap_in),
    .pwm_out(pwm_out), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic evt();
    cnt_evt = 1'b1;
    @(negedge clk);
    cnt_evt = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog: got hang expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(3'd2, rv); check("R1 count", rv, 16'h0000);
    rd(3'd0, rv); check("R1 ctrl", rv, 16'h0000);
    rd(3'd1, rv); check("R1 status", rv, 16'h0000);
    check("R1 pwm", {15'd0, pwm_out}, 16'd0);
    check("R1 irq", {15'd0, irq}, 16'd0);
    wr(3'd2, 16'hFFFE);
    wr(3'd0, 16'h0001);
    evt(); rd(3'd2, rv); check("R1 period ffff step", rv, 16'hFFFF);
    rd(3'd1, rv); check("R1 no early ovf", rv, 16'h0000);
    evt(); rd(3'd2, rv); check("R1 wrap at ffff", rv, 16'h0000);
    rd(3'd1, rv); check("R1 ovf after wrap", rv, 16'h0001);

    // R6 period reads zero
    wr(3'd3, 16'h0002);
    rd(3'd3, rv); check("R6 period read", rv, 16'h0000);

    // R2, R3 prescale sweep over every code, period 2
    for (int code = 0; code < 8; code++) begin
      wr(3'd0, 16'h0000);
      wr(3'd2, 16'h0000);
      wr(3'd1, 16'h0000);
      wr(3'd0, 16'(1 | (code << 3)));
      for (int n = 1; n <= 3 * (1 << code); n++) begin
        evt();
        rd(3'd2, rv);
        check($sformatf("R2 code %0d ev %0d", code, n), rv, 16'(((n >> code)) % 3));
        if (n == 3 * (1 << code) - 1) begin
          rd(3'd1, rv); check("R3 not yet", rv, 16'h0000);
        end
      end
      rd(3'd1, rv); check($sformatf("R3 ovf code %0d", code), rv, 16'h0001);
    end

    // R11 write 1 keeps, write 0 clears
    wr(3'd1, 16'h0001); rd(3'd1, rv); check("R11 keep", rv, 16'h0001);
    // R12 mask
    wr(3'd0, 16'h0040); @(negedge clk); @(negedge clk);
    check("R12 irq on", {15'd0, irq}, 16'd1);
    wr(3'd0, 16'h0000); @(negedge clk); @(negedge clk);
    check("R12 irq masked", {15'd0, irq}, 16'd0);
    wr(3'd1, 16'h0002); rd(3'd1, rv); check("R11 clear", rv, 16'h0000);

    // R4 disabled holds; divider discarded on disable
    wr(3'd2, 16'h0000);
    evt(); evt(); rd(3'd2, rv); check("R4 disabled hold", rv, 16'h0000);
    wr(3'd0, 16'h0011);               // code 2, enabled
    evt(); evt(); evt();
    wr(3'd0, 16'h0010);               // disable
    wr(3'd0, 16'h0011);
    evt(); rd(3'd2, rv); check("R4 divider reset", rv, 16'h0000);
    evt(); evt(); evt(); rd(3'd2, rv); check("R4 full group", rv, 16'h0001);
    evt(); evt(); evt();
    wr(3'd0, 16'h0019);               // code change to 3
    evt(); rd(3'd2, rv); check("R4 code change reset", rv, 16'h0001);

    // R5 write beats tick
    wr(3'd0, 16'h0001);
    wr(3'd3, 16'h00FF);
    cnt_evt = 1'b1; wr(3'd2, 16'h0050); cnt_evt = 1'b0;
    rd(3'd2, rv); check("R5 write wins", rv, 16'h0050);

    // R7 pulse output sweep, period 7
    wr(3'd3, 16'h0007);
    for (int d = 0; d < 10; d++) begin
      wr(3'd0, 16'h0000);
      wr(3'd2, 16'h0000);
      wr(3'd4, 16'(d));
      wr(3'd0, 16'h0003);
      @(negedge clk);
      check($sformatf("R7 d%0d n0", d), {15'd0, pwm_out}, 16'(0 < d));
      for (int n = 1; n <= 16; n++) begin
        evt();
        @(negedge clk);
        check($sformatf("R7 d%0d n%0d", d, n), {15'd0, pwm_out}, 16'((n % 8) < d));
      end
    end
    wr(3'd0, 16'h0001); @(negedge clk); @(negedge clk);
    check("R7 timer mode low", {15'd0, pwm_out}, 16'd0);

    // R9 capture ignored outside capture mode
    wr(3'd1, 16'h0000);
    wr(3'd4, 16'h4242);
    cap_in = 1'b1; repeat (4) @(negedge clk); cap_in = 1'b0;
    rd(3'd4, rv); check("R9 duty kept", rv, 16'h4242);
    rd(3'd1, rv); check("R9 no pend", rv, 16'h0000);

    // R8 capture
    wr(3'd0, 16'h0085);
    wr(3'd2, 16'h1234);
    cap_in = 1'b1; repeat (3) @(negedge clk); cap_in = 1'b0;
    rd(3'd4, rv); check("R8 captured", rv, 16'h1234);
    rd(3'd1, rv); check("R8 cap pend", rv, 16'h0002);
    @(negedge clk);
    check("R12 capture irq", {15'd0, irq}, 16'd1);
    wr(3'd1, 16'h0000);
    repeat (3) @(negedge clk);

    // R10 capture and duty write collide
    wr(3'd2, 16'h0777);
    cap_in = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(3'd4, 16'hBEEF);
    cap_in = 1'b0;
    rd(3'd4, rv); check("R10 capture wins", rv, 16'h0777);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule